// File: doc/BRIEF.md
# Clockless-Handshake Backplane Target Port

This block is the target side of a parallel backplane on which transfers are paced by strobes and acknowledgements rather than by a shared clock. A bus master places an address, an address-space code and a read/write direction on the bus, then lowers an address strobe and a data strobe. The block brings both strobes into its own clock domain and decides whether the access is meant for it. If the access is addressed to it, the block either completes the transfer against a small local register bank or refuses it. Every step waits on the other party, so the master has no fixed latency to rely on.

The address-space code does two jobs. It says whether the access is valid, and it picks how many address bits take part in the window match: a short code compares only the low address bits, and a long code compares the whole address. A completed transfer is answered on the success line. A refused transfer is answered on a separate failure line. An access whose address falls outside the window gets no answer of any kind, so another target on the backplane can claim it. Any answer stays asserted until the master lifts the data strobe.

Top module: `bpl_slave`

## Requirements
- R1: After reset, `xfer_ok_n` and `xfer_fail_n` are high, and `rdata_oe` is low.
- R2: Both strobes pass through a two-stage synchroniser. When both strobes go low before a clock edge, the answer first appears after the third rising edge.
- R3: A write with the long code (6'h3A), an address whose bits [23:4] equal the base 24'h12345x, and a register index (bits [3:0]) below 8 stores `bus_wdata` in that register and answers on `xfer_ok_n`.
- R4: A read that is valid under the rules of R3 answers on `xfer_ok_n` and, for as long as that answer lasts, drives the addressed register's value on `bus_rdata` with `rdata_oe` high.
- R5: An answer holds while the data strobe stays low. It is removed after the third rising edge following the data strobe's return to high. `xfer_ok_n` and `xfer_fail_n` are never low together.
- R6: An in-window access with a code that is neither 6'h2A nor 6'h3A answers on `xfer_fail_n` and changes no register. For such codes, the window is judged on the full address.
- R7: An in-window access with a valid code and a register index of 8 to 15 answers on `xfer_fail_n`.
- R8: An access outside the window gets no answer on either line, does not raise `rdata_oe`, and writes nothing.
- R9: The short code (6'h2A) matches the window on address bits [15:4] only, so upper address bits are ignored. The long code requires every bit of [23:4] to match.
- R10: `rdata_oe` is high only while a read's success answer is active. Writes never drive read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that samples the strobes |
| rst_n | input | 1 | Active-low asynchronous-assert reset |
| bus_addr | input | 24 | Word address from the master |
| bus_code | input | 6 | Address-space code from the master |
| addr_stb_n | input | 1 | Address strobe, active low, asynchronous |
| data_stb_n | input | 1 | Data strobe, active low, asynchronous |
| bus_write_n | input | 1 | Direction: low for write, high for read |
| bus_wdata | input | 16 | Write data from the master |
| bus_rdata | output | 16 | Read data driven by this target |
| rdata_oe | output | 1 | High while `bus_rdata` carries valid read data |
| xfer_ok_n | output | 1 | Success answer, active low |
| xfer_fail_n | output | 1 | Failure answer, active low |

## Verification
The checker watches the handshake on every cycle. The two answer lines must never be active together. An answer must hold while the synchronised data strobe is active, and must drop one cycle after that strobe goes inactive. An answer may start only after both strobes were low, and read data may be driven only during a read's success answer. Several behaviours can be shown only by the bench's directed transfers: the exact latency in edges, the stored values read back after writes, the short versus long window match, and the failures for a bad code or a missing register. The same goes for showing that writes which were ignored or refused left every register unchanged.

// File: rtl/bpl_pkg.sv
package bpl_pkg;

   // handshake sequencer states
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DONE = 2'd1,
      ST_FAIL = 2'd2,
      ST_SKIP = 2'd3
   } bpl_state_e;

   // outcome of address and code decode
   typedef struct packed {
      logic in_win;
      logic code_ok;
      logic reg_ok;
   } bpl_dec_t;

endpackage

// File: rtl/bpl_sync.sv
module bpl_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 1,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
      end else begin
         pipe[0] <= d;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/bpl_decode.sv
module bpl_decode
   import bpl_pkg::*;
#(
   parameter int              ADDR_W     = 24,
   parameter int              CODE_W     = 6,
   parameter int              SHORT_W    = 16,
   parameter int              WIN_LSB    = 4,
   parameter int              NREGS      = 8,
   parameter logic [ADDR_W-1:0] BASE     = 24'h123450,
   parameter logic [CODE_W-1:0] CODE_SHORT = 6'h2A,
   parameter logic [CODE_W-1:0] CODE_LONG  = 6'h3A
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [CODE_W-1:0]  code,
   output bpl_dec_t           dec,
   output logic [WIN_LSB-1:0] idx
);

   logic is_short, is_long, short_hit, long_hit, reg_ok;

   assign is_short  = (code == CODE_SHORT);
   assign is_long   = (code == CODE_LONG);
   assign short_hit = (addr[SHORT_W-1:WIN_LSB] == BASE[SHORT_W-1:WIN_LSB]);
   assign long_hit  = (addr[ADDR_W-1:WIN_LSB]  == BASE[ADDR_W-1:WIN_LSB]);
   assign idx       = addr[WIN_LSB-1:0];

   generate
      if (NREGS == (2 ** WIN_LSB)) begin : g_full_window
         assign reg_ok = 1'b1;
      end else begin : g_part_window
         localparam logic [WIN_LSB:0] NREGS_V = NREGS[WIN_LSB:0];
         assign reg_ok = ({1'b0, idx} < NREGS_V);
      end
   endgenerate

   always_comb begin
      dec.in_win  = is_short ? short_hit : long_hit;
      dec.code_ok = is_short | is_long;
      dec.reg_ok  = reg_ok;
   end

endmodule

// File: rtl/bpl_regfile.sv
module bpl_regfile #(
   parameter int DATA_W = 16,
   parameter int NREGS  = 8,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int SEL_W = $clog2(NREGS);
   localparam logic [IDX_W:0] LIMIT = NREGS[IDX_W:0];

   logic [DATA_W-1:0] mem [NREGS];
   logic              idx_ok;

   assign idx_ok = ({1'b0, idx} < LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREGS; r++) mem[r] <= '0;
      end else if (wr_en && idx_ok) begin
         mem[idx[SEL_W-1:0]] <= wdata;
      end
   end

   assign rdata = idx_ok ? mem[idx[SEL_W-1:0]] : '0;

endmodule

// File: rtl/bpl_fsm.sv
module bpl_fsm
   import bpl_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              astb,
   input  logic              dstb,
   input  logic              is_wr,
   input  bpl_dec_t          dec,
   input  logic [DATA_W-1:0] rd_value,
   output logic              wr_en,
   output logic              ok,
   output logic              fail,
   output logic              oe,
   output logic [DATA_W-1:0] rdata
);

   bpl_state_e        st;
   logic              was_rd;
   logic [DATA_W-1:0] rd_q;
   logic              start, good;

   assign start = (st == ST_IDLE) && astb && dstb;
   assign good  = dec.in_win && dec.code_ok && dec.reg_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         was_rd <= 1'b0;
         rd_q   <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (astb && dstb) begin
                  if (!dec.in_win) begin
                     st <= ST_SKIP;
                  end else if (!dec.code_ok || !dec.reg_ok) begin
                     st <= ST_FAIL;
                  end else begin
                     st     <= ST_DONE;
                     was_rd <= !is_wr;
                     if (!is_wr) rd_q <= rd_value;
                  end
               end
            end
            default: begin
               if (!dstb) st <= ST_IDLE;
            end
         endcase
      end
   end

   assign wr_en = start && good && is_wr;
   assign ok    = (st == ST_DONE);
   assign fail  = (st == ST_FAIL);
   assign oe    = (st == ST_DONE) && was_rd;
   assign rdata = oe ? rd_q : '0;

endmodule

// File: rtl/bpl_slave.sv
module bpl_slave
   import bpl_pkg::*;
#(
   parameter int                ADDR_W     = 24,
   parameter int                DATA_W     = 16,
   parameter int                CODE_W     = 6,
   parameter int                SHORT_W    = 16,
   parameter int                WIN_LSB    = 4,
   parameter int                NREGS      = 8,
   parameter int                STAGES     = 2,
   parameter logic [ADDR_W-1:0] BASE       = 24'h123450,
   parameter logic [CODE_W-1:0] CODE_SHORT = 6'h2A,
   parameter logic [CODE_W-1:0] CODE_LONG  = 6'h3A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CODE_W-1:0] bus_code,
   input  logic              addr_stb_n,
   input  logic              data_stb_n,
   input  logic              bus_write_n,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              rdata_oe,
   output logic              xfer_ok_n,
   output logic              xfer_fail_n
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("STAGES must be at least 2");
      end
      if (NREGS < 2 || NREGS > (2 ** WIN_LSB)) begin : g_bad_nregs
         $error("NREGS must lie in 2 .. 2**WIN_LSB");
      end
      if (SHORT_W <= WIN_LSB || SHORT_W > ADDR_W) begin : g_bad_short
         $error("SHORT_W must exceed WIN_LSB and not exceed ADDR_W");
      end
      if (CODE_SHORT == CODE_LONG) begin : g_bad_codes
         $error("address-space codes must differ");
      end
   endgenerate

   logic [1:0]         stb_q;
   logic               astb_s, dstb_s;
   bpl_dec_t           dec;
   logic [WIN_LSB-1:0] idx;
   logic [DATA_W-1:0]  reg_rd;
   logic               wr_en, ok, fail;

   bpl_sync #(.STAGES(STAGES), .W(2), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({addr_stb_n, data_stb_n}),
      .q     (stb_q)
   );

   assign astb_s = !stb_q[1];
   assign dstb_s = !stb_q[0];

   bpl_decode #(
      .ADDR_W(ADDR_W), .CODE_W(CODE_W), .SHORT_W(SHORT_W), .WIN_LSB(WIN_LSB),
      .NREGS(NREGS), .BASE(BASE), .CODE_SHORT(CODE_SHORT), .CODE_LONG(CODE_LONG)
   ) u_dec (
      .addr (bus_addr),
      .code (bus_code),
      .dec  (dec),
      .idx  (idx)
   );

   bpl_regfile #(.DATA_W(DATA_W), .NREGS(NREGS), .IDX_W(WIN_LSB)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .idx   (idx),
      .wdata (bus_wdata),
      .rdata (reg_rd)
   );

   bpl_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .astb     (astb_s),
      .dstb     (dstb_s),
      .is_wr    (!bus_write_n),
      .dec      (dec),
      .rd_value (reg_rd),
      .wr_en    (wr_en),
      .ok       (ok),
      .fail     (fail),
      .oe       (rdata_oe),
      .rdata    (bus_rdata)
   );

   assign xfer_ok_n   = !ok;
   assign xfer_fail_n = !fail;

endmodule

// File: rtl/bpl_slave_chk.sv
module bpl_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic addr_stb_n,
   input logic data_stb_n,
   input logic bus_write_n,
   input logic rdata_oe,
   input logic xfer_ok_n,
   input logic xfer_fail_n,
   input logic dstb_sync
);

   // R5
   answer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!xfer_ok_n && !xfer_fail_n));

   // R5
   answer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!xfer_ok_n || !xfer_fail_n) && dstb_sync) |=> $stable({xfer_ok_n, xfer_fail_n}));

   // R5
   answer_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dstb_sync |=> (xfer_ok_n && xfer_fail_n));

   // R2
   answer_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(xfer_ok_n) || $fell(xfer_fail_n)) |-> ($past(!data_stb_n) && $past(!addr_stb_n)));

   // R10
   read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> (bus_write_n && !xfer_ok_n));

endmodule

bind bpl_slave bpl_slave_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr_stb_n  (addr_stb_n),
   .data_stb_n  (data_stb_n),
   .bus_write_n (bus_write_n),
   .rdata_oe    (rdata_oe),
   .xfer_ok_n   (xfer_ok_n),
   .xfer_fail_n (xfer_fail_n),
   .dstb_sync   (dstb_s)
);

// File: tb/sim_bpl_slave.sv
`timescale 1ns/1ps
module sim_bpl_slave;

   localparam logic [5:0] C_SHORT = 6'h2A;
   localparam logic [5:0] C_LONG  = 6'h3A;
   localparam logic [5:0] C_BAD   = 6'h3F;
   localparam int NONE = 0, OK = 1, FAILR = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] bus_addr = '0;
   logic [5:0]  bus_code = '0;
   logic        addr_stb_n = 1'b1;
   logic        data_stb_n = 1'b1;
   logic        bus_write_n = 1'b1;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        rdata_oe, xfer_ok_n, xfer_fail_n;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   bpl_slave u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_code(bus_code),
      .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n), .bus_write_n(bus_write_n),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rdata_oe(rdata_oe),
      .xfer_ok_n(xfer_ok_n), .xfer_fail_n(xfer_fail_n)
   );

   function automatic logic [15:0] pat(input int i);
      return 16'hA000 + 16'(i * 16'h0111);
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   // one full strobe handshake; checks latency and release timing itself
   task automatic cycle(input logic [23:0] a, input logic [5:0] c, input bit wr,
                        input logic [15:0] wd, output int resp,
                        output logic [15:0] rd, output bit oe);
      int lat = 0;
      int rel = 0;
      bit seen_oe = 1'b0;
      resp = NONE; rd = '0;
      @(negedge clk);
      bus_addr = a; bus_code = c; bus_write_n = !wr; bus_wdata = wd;
      addr_stb_n = 1'b0; data_stb_n = 1'b0;
      for (int i = 1; i <= 8; i++) begin
         @(negedge clk);
         if (rdata_oe) seen_oe = 1'b1;
         if (!xfer_ok_n || !xfer_fail_n) begin lat = i; break; end
      end
      if (lat != 0) begin
         resp = !xfer_ok_n ? OK : FAILR;
         rd = bus_rdata;
         chk("R2 answer latency", lat, 3);
         repeat (2) @(negedge clk);
         chk("R5 answer held", {xfer_ok_n, xfer_fail_n}, (resp == OK) ? 2'b01 : 2'b10);
      end
      oe = seen_oe;
      addr_stb_n = 1'b1; data_stb_n = 1'b1;
      for (int i = 1; i <= 8; i++) begin
         @(negedge clk);
         if (xfer_ok_n && xfer_fail_n && !rdata_oe) begin rel = i; break; end
      end
      if (lat != 0) chk("R5 release latency", rel, 3);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 ok idle", xfer_ok_n, 1);
      chk("R1 fail idle", xfer_fail_n, 1);
      chk("R1 oe idle", rdata_oe, 0);
   endtask

   task automatic t_write_read();
      int r; logic [15:0] d; bit oe;
      for (int i = 0; i < 8; i++) begin
         cycle(24'h123450 + 24'(i), C_LONG, 1'b1, pat(i), r, d, oe);
         chk("R3 write answer", r, OK);
         chk("R10 no drive on write", oe, 0);
      end
      for (int i = 7; i >= 0; i--) begin
         cycle(24'h123450 + 24'(i), C_LONG, 1'b0, 16'h0, r, d, oe);
         chk("R4 read answer", r, OK);
         chk("R4 read oe", oe, 1);
         chk("R4 read data", d, pat(i));
      end
   endtask

   task automatic t_short();
      int r; logic [15:0] d; bit oe;
      cycle(24'hFF3452, C_SHORT, 1'b1, 16'hBEEF, r, d, oe);
      chk("R9 short code ignores upper bits", r, OK);
      cycle(24'h123452, C_LONG, 1'b0, 16'h0, r, d, oe);
      chk("R9 short write landed", d, 16'hBEEF);
      cycle(24'hFF3452, C_LONG, 1'b1, 16'h1111, r, d, oe);
      chk("R9 long code needs full match", r, NONE);
      cycle(24'h003455, C_SHORT, 1'b0, 16'h0, r, d, oe);
      chk("R9 short read answer", r, OK);
      chk("R9 short read data", d, pat(5));
   endtask

   task automatic t_bad_code();
      int r; logic [15:0] d; bit oe;
      cycle(24'h123453, C_BAD, 1'b1, 16'hDEAD, r, d, oe);
      chk("R6 bad code fails", r, FAILR);
      chk("R6 no drive", oe, 0);
      cycle(24'h123453, C_LONG, 1'b0, 16'h0, r, d, oe);
      chk("R6 register untouched", d, pat(3));
   endtask

   task automatic t_bad_reg();
      int r; logic [15:0] d; bit oe;
      cycle(24'h12345A, C_LONG, 1'b0, 16'h0, r, d, oe);
      chk("R7 missing register read fails", r, FAILR);
      chk("R7 no drive", oe, 0);
      cycle(24'h12345F, C_SHORT, 1'b1, 16'h7777, r, d, oe);
      chk("R7 missing register write fails", r, FAILR);
   endtask

   task automatic t_ignore();
      int r; logic [15:0] d; bit oe;
      cycle(24'h223454, C_LONG, 1'b1, 16'h5555, r, d, oe);
      chk("R8 outside window silent", r, NONE);
      chk("R8 no drive", oe, 0);
      cycle(24'h223451, C_BAD, 1'b1, 16'h6666, r, d, oe);
      chk("R8 bad code outside window silent", r, NONE);
      cycle(24'h123454, C_LONG, 1'b0, 16'h0, r, d, oe);
      chk("R8 register 4 untouched", d, pat(4));
      cycle(24'h123451, C_LONG, 1'b0, 16'h0, r, d, oe);
      chk("R8 register 1 untouched", d, pat(1));
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_write_read();
      t_short();
      t_bad_code();
      t_bad_reg();
      t_ignore();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule